// File: doc/BRIEF.md
# Frame synchronization controller

This controller splits a spiking-network simulation into fixed time steps (frames) and keeps the processors and the packet network in lockstep. Each processor pulses a done line once it has updated every source neuron it owns for the current step. Network ports report every spike packet they inject and every packet they deliver. The controller declares a frame boundary only when all processors have finished and no packet is still in flight.

When the network drains before the processors finish, frames follow one another with no gap and the processor enable never drops. When traffic outlasts the computation, the enable is pulled low until the last packet lands, so heavy spiking stretches the frame instead of corrupting it. At every boundary a one-cycle frame-complete pulse is raised and a wrapping frame counter advances.

A halt request parks the whole system at the next boundary, with the processors disabled. This lets configuration packets be injected and delivered between steps. The halt is released once the request drops and that configuration traffic has drained.

Top module: `frame_sync_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, proc_en_o is 1, frame_done_o is 0, halted_o is 0, frame_cnt_o is 0 and inflight_o is 0.
- R2: inflight_o equals the total of set bits ever seen on pkt_inj_i minus the total seen on pkt_dlv_i (modulo 2^CNT_W). Several ports may pulse in one cycle, and injection and delivery may happen in the same cycle. The value updates one clock edge after the pulses.
- R3: A done pulse from a processor is remembered until the next boundary, so the processors may finish in any order and in different cycles. No boundary occurs while any processor has not pulsed done in the current frame.
- R4: If the network is idle, a done pulse that completes the set at edge N gives frame_done_o = 1 after edge N+1, and proc_en_o stays 1 throughout (no stall).
- R5: If packets are outstanding when the set completes, proc_en_o is 0 from edge N+1 on. It stays 0 until an edge where the injected and delivered totals are equal and no injection is present. At that edge frame_done_o and proc_en_o both become 1.
- R6: An injection pulse present in the cycle the boundary is evaluated counts as outstanding traffic and forces a stall.
- R7: frame_done_o is high for exactly the cycle after each boundary edge, and frame_cnt_o increases by one at that same edge, wrapping at 2^FRAME_W.
- R8: halt_req_i has no effect during a frame. At a boundary with halt_req_i = 1, frame_done_o pulses, halted_o becomes 1 and proc_en_o becomes 0.
- R9: The halted state is left only at an edge where halt_req_i = 0, the in-flight total is zero and no injection is present. Then halted_o = 0 and proc_en_o = 1, with no frame_done_o pulse.
- R10: A done pulse that arrives in the same cycle as a boundary edge is kept for the following frame rather than being cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| proc_done_i | input | NUM_PROC | One-cycle pulse per processor: its source neurons for this step are updated |
| pkt_inj_i | input | NUM_PORT | One-cycle pulse per port: a packet entered the network |
| pkt_dlv_i | input | NUM_PORT | One-cycle pulse per port: a packet reached its destination |
| halt_req_i | input | 1 | Level request to park the system at the next frame boundary |
| proc_en_o | output | 1 | Processor clock enable; low while stalled or halted |
| frame_done_o | output | 1 | One-cycle pulse after each frame boundary |
| frame_cnt_o | output | FRAME_W | Number of completed frames, wrapping |
| halted_o | output | 1 | System parked for configuration |
| inflight_o | output | CNT_W | Packets injected but not yet delivered |

## Verification
Two coincidences get the most attention. The first is a done pulse that lands on the very edge where the boundary clears the done record. The bench raises all done lines in the evaluation cycle and expects a second frame_done_o pulse on the next edge; it would see none if the clear won. The second is an injection in the cycle where the boundary is evaluated, and in the halted state a release edge that coincides with configuration traffic. In both cases the bench expects the enable to stay low, and checks each boundary's frame number against a queue of expected values.

// File: rtl/frame_sync_pkg.sv
package frame_sync_pkg;

   typedef enum logic [1:0] {
      FS_RUN   = 2'd0,
      FS_DRAIN = 2'd1,
      FS_HALT  = 2'd2
   } fs_state_e;

endpackage

// File: rtl/fsc_done_tracker.sv
module fsc_done_tracker #(
   parameter int NUM_PROC = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PROC-1:0] done_pulse_i,
   input  logic                clr_i,
   output logic                all_done_o
);

   if (NUM_PROC < 1) begin : g_bad_nproc
      $error("fsc_done_tracker: NUM_PROC must be at least 1");
   end

   logic [NUM_PROC-1:0] done_q;

   // a fresh pulse outranks the boundary clear so it counts for the next frame
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_q <= '0;
      end else begin
         for (int p = 0; p < NUM_PROC; p++) begin
            if (done_pulse_i[p])
               done_q[p] <= 1'b1;
            else if (clr_i)
               done_q[p] <= 1'b0;
         end
      end
   end

   assign all_done_o = &done_q;

   AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && done_pulse_i == '0) |=> (done_q == '0)); // R3

   AST_PULSE_SURVIVES_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && done_pulse_i != '0) |=> (done_q != '0)); // R10

endmodule

// File: rtl/fsc_traffic_meter.sv
module fsc_traffic_meter #(
   parameter int NUM_PORT = 4,
   parameter int CNT_W    = 10
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PORT-1:0] inj_i,
   input  logic [NUM_PORT-1:0] dlv_i,
   output logic [CNT_W-1:0]    inflight_o,
   output logic                idle_o
);

   localparam int NW = $clog2(NUM_PORT + 1);

   if (NUM_PORT < 1) begin : g_bad_nport
      $error("fsc_traffic_meter: NUM_PORT must be at least 1");
   end
   if (CNT_W <= NW) begin : g_bad_cntw
      $error("fsc_traffic_meter: CNT_W too narrow for the port count");
   end

   logic [NW-1:0]    inj_n, dlv_n;
   logic [CNT_W-1:0] inj_tot, dlv_tot;

   if (NUM_PORT == 1) begin : g_single
      assign inj_n = inj_i;
      assign dlv_n = dlv_i;
   end else begin : g_multi
      always_comb begin
         inj_n = '0;
         dlv_n = '0;
         for (int k = 0; k < NUM_PORT; k++) begin
            inj_n = inj_n + NW'(inj_i[k]);
            dlv_n = dlv_n + NW'(dlv_i[k]);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         inj_tot <= '0;
         dlv_tot <= '0;
      end else begin
         inj_tot <= inj_tot + CNT_W'(inj_n);
         dlv_tot <= dlv_tot + CNT_W'(dlv_n);
      end
   end

   assign inflight_o = inj_tot - dlv_tot;
   // a packet entering this cycle is not in the totals yet but is still traffic
   assign idle_o     = (inj_tot == dlv_tot) && (inj_i == '0);

   AST_NO_EXCESS_DELIVERY: assert property (@(posedge clk) disable iff (!rst_n)
      CNT_W'(dlv_n) <= inflight_o); // R2

endmodule

// File: rtl/fsc_frame_fsm.sv
module fsc_frame_fsm
   import frame_sync_pkg::*;
#(
   parameter int FRAME_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               all_done_i,
   input  logic               idle_i,
   input  logic               halt_req_i,
   output logic               boundary_o,
   output logic               proc_en_o,
   output logic               halted_o,
   output logic               frame_done_o,
   output logic [FRAME_W-1:0] frame_cnt_o
);

   if (FRAME_W < 1) begin : g_bad_fw
      $error("fsc_frame_fsm: FRAME_W must be at least 1");
   end

   fs_state_e state_q, state_d;
   logic      bnd;

   always_comb begin
      state_d = state_q;
      bnd     = 1'b0;
      unique case (state_q)
         FS_RUN: begin
            if (all_done_i) begin
               if (idle_i) begin
                  bnd     = 1'b1;
                  state_d = halt_req_i ? FS_HALT : FS_RUN;
               end else begin
                  state_d = FS_DRAIN;
               end
            end
         end
         FS_DRAIN: begin
            if (idle_i) begin
               bnd     = 1'b1;
               state_d = halt_req_i ? FS_HALT : FS_RUN;
            end
         end
         FS_HALT: begin
            if (!halt_req_i && idle_i)
               state_d = FS_RUN;
         end
         default: state_d = FS_RUN;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q      <= FS_RUN;
         frame_done_o <= 1'b0;
         frame_cnt_o  <= '0;
      end else begin
         state_q      <= state_d;
         frame_done_o <= bnd;
         if (bnd)
            frame_cnt_o <= frame_cnt_o + 1'b1;
      end
   end

   assign boundary_o = bnd;
   assign proc_en_o  = (state_q == FS_RUN);
   assign halted_o   = (state_q == FS_HALT);

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done_o |-> frame_cnt_o == $past(frame_cnt_o) + 1'b1); // R7

   AST_HALT_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(halted_o) |-> frame_done_o); // R8

   AST_STALL_NEEDS_TRAFFIC: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(proc_en_o) && !halted_o) |-> !$past(idle_i)); // R5

   AST_RESUME_WITH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(proc_en_o) && !$past(halted_o)) |-> frame_done_o); // R5

   AST_HALT_RELEASE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(halted_o) |-> (!frame_done_o && !$past(halt_req_i))); // R9

endmodule

// File: rtl/frame_sync_ctrl.sv
module frame_sync_ctrl #(
   parameter int NUM_PROC = 4,
   parameter int NUM_PORT = 4,
   parameter int CNT_W    = 10,
   parameter int FRAME_W  = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PROC-1:0] proc_done_i,
   input  logic [NUM_PORT-1:0] pkt_inj_i,
   input  logic [NUM_PORT-1:0] pkt_dlv_i,
   input  logic                halt_req_i,
   output logic                proc_en_o,
   output logic                frame_done_o,
   output logic [FRAME_W-1:0]  frame_cnt_o,
   output logic                halted_o,
   output logic [CNT_W-1:0]    inflight_o
);

   logic all_done, net_idle, boundary;

   fsc_done_tracker #(
      .NUM_PROC (NUM_PROC)
   ) u_done (
      .clk          (clk),
      .rst_n        (rst_n),
      .done_pulse_i (proc_done_i),
      .clr_i        (boundary),
      .all_done_o   (all_done)
   );

   fsc_traffic_meter #(
      .NUM_PORT (NUM_PORT),
      .CNT_W    (CNT_W)
   ) u_meter (
      .clk        (clk),
      .rst_n      (rst_n),
      .inj_i      (pkt_inj_i),
      .dlv_i      (pkt_dlv_i),
      .inflight_o (inflight_o),
      .idle_o     (net_idle)
   );

   fsc_frame_fsm #(
      .FRAME_W (FRAME_W)
   ) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .all_done_i   (all_done),
      .idle_i       (net_idle),
      .halt_req_i   (halt_req_i),
      .boundary_o   (boundary),
      .proc_en_o    (proc_en_o),
      .halted_o     (halted_o),
      .frame_done_o (frame_done_o),
      .frame_cnt_o  (frame_cnt_o)
   );

   AST_BOUNDARY_NEEDS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done_o |-> $past(all_done) || $past(!proc_en_o)); // R3

endmodule

// File: tb/frame_sync_ctrl_bench.sv
`timescale 1ns/1ps
module frame_sync_ctrl_bench;

   localparam int NP = 3, NPT = 4, FW = 4, CW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NP-1:0] proc_done = '0;
   logic [NPT-1:0] inj = '0, dlv = '0;
   logic          halt_req = 1'b0;
   logic          proc_en, frame_done, halted;
   logic [FW-1:0] frame_cnt;
   logic [CW-1:0] inflight;

   int n_cmp = 0, n_bad = 0;
   bit finished = 0;
   logic [FW-1:0] exp_q[$];
   logic [FW-1:0] model_cnt = '0;

   always #2 clk = ~clk;

   frame_sync_ctrl #(.NUM_PROC(NP), .NUM_PORT(NPT), .CNT_W(CW), .FRAME_W(FW)) u_frame_sync_ctrl (
      .clk(clk), .rst_n(rst_n), .proc_done_i(proc_done), .pkt_inj_i(inj), .pkt_dlv_i(dlv),
      .halt_req_i(halt_req), .proc_en_o(proc_en), .frame_done_o(frame_done),
      .frame_cnt_o(frame_cnt), .halted_o(halted), .inflight_o(inflight));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   // driver side of the scoreboard
   task automatic expect_frame();
      model_cnt = model_cnt + 1'b1;
      exp_q.push_back(model_cnt);
   endtask

   // monitor side: every boundary pulse must match the next queued frame number
   always @(posedge clk) begin : mon
      logic [FW-1:0] e;
      #1;
      if (rst_n && frame_done) begin
         if (exp_q.size() == 0) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R7 unexpected boundary: actual %0d expected none", frame_cnt);
         end else begin
            e = exp_q.pop_front();
            chk("R7 frame number", frame_cnt, e);
         end
      end
   end

   initial begin
      #(4 * 20000);
      if (!finished) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) tick();
      chk("R1 enable in reset", proc_en, 1);
      chk("R1 done in reset", frame_done, 0);
      rst_n = 1'b1;
      tick();
      chk("R1 enable", proc_en, 1);
      chk("R1 frame done", frame_done, 0);
      chk("R1 count", frame_cnt, 0);
      chk("R1 halted", halted, 0);
      chk("R1 inflight", inflight, 0);

      // R4: idle network, back-to-back frame
      proc_done = '1; tick(); proc_done = '0;
      chk("R4 not yet", frame_done, 0);
      chk("R4 enable", proc_en, 1);
      expect_frame(); tick();
      chk("R4 boundary", frame_done, 1);
      chk("R4 no stall", proc_en, 1);
      tick();
      chk("R7 single pulse", frame_done, 0);

      // R3: done pulses in different cycles, one held back
      proc_done = 3'b001; tick(); proc_done = '0; tick();
      proc_done = 3'b100; tick(); proc_done = '0;
      for (int i = 0; i < 3; i++) begin
         tick();
         chk("R3 incomplete set", frame_done, 0);
         chk("R3 enable", proc_en, 1);
      end
      proc_done = 3'b010; tick(); proc_done = '0;
      expect_frame(); tick();
      chk("R3 complete set", frame_done, 1);

      // R2 and R5: traffic outlasts computation
      inj = 4'b0111; tick(); inj = '0;
      chk("R2 three injected", inflight, 3);
      tick();
      proc_done = '1; tick(); proc_done = '0;
      tick();
      chk("R5 stalled", proc_en, 0);
      chk("R5 no boundary", frame_done, 0);
      dlv = 4'b0011; tick(); dlv = '0;
      chk("R2 two delivered", inflight, 1);
      chk("R5 still stalled", proc_en, 0);
      inj = 4'b1000; dlv = 4'b0100; tick(); inj = '0; dlv = '0;
      chk("R2 same cycle in and out", inflight, 1);
      chk("R5 stalled", proc_en, 0);
      dlv = 4'b1000; tick(); dlv = '0;
      chk("R2 drained", inflight, 0);
      chk("R5 stall until idle edge", proc_en, 0);
      expect_frame(); tick();
      chk("R5 boundary", frame_done, 1);
      chk("R5 resume", proc_en, 1);

      // R6: injection in the evaluation cycle
      proc_done = '1; tick(); proc_done = '0;
      inj = 4'b0001; tick(); inj = '0;
      chk("R6 stall", proc_en, 0);
      chk("R6 no boundary", frame_done, 0);
      chk("R6 inflight", inflight, 1);
      dlv = 4'b0001; tick(); dlv = '0;
      chk("R6 still stalled", proc_en, 0);
      expect_frame(); tick();
      chk("R6 boundary", frame_done, 1);

      // R8: halt only at a boundary
      halt_req = 1'b1;
      for (int i = 0; i < 3; i++) begin
         tick();
         chk("R8 running", proc_en, 1);
         chk("R8 not halted", halted, 0);
      end
      proc_done = '1; tick(); proc_done = '0;
      expect_frame(); tick();
      chk("R8 boundary", frame_done, 1);
      chk("R8 halted", halted, 1);
      chk("R8 enable low", proc_en, 0);
      tick();
      chk("R9 held", halted, 1);

      // R9: configuration traffic during halt
      inj = 4'b0010; halt_req = 1'b0; tick(); inj = '0;
      chk("R9 injection keeps halt", halted, 1);
      dlv = 4'b0010; tick(); dlv = '0;
      chk("R9 outstanding keeps halt", halted, 1);
      tick();
      chk("R9 released", halted, 0);
      chk("R9 enable", proc_en, 1);
      chk("R9 no pulse", frame_done, 0);

      // R10: done pulse on the boundary edge
      proc_done = '1; tick();
      expect_frame(); tick(); proc_done = '0;
      chk("R10 first boundary", frame_done, 1);
      expect_frame(); tick();
      chk("R10 kept pulse boundary", frame_done, 1);
      tick();
      chk("R10 quiet", frame_done, 0);

      // R7: counter wrap
      for (int f = 0; f < 12; f++) begin
         proc_done = '1; tick(); proc_done = '0;
         expect_frame(); tick();
      end
      tick();
      chk("R7 wrapped count", frame_cnt, 3);
      if (exp_q.size() != 0) begin
         n_cmp++;
         n_bad++;
         $display("FAIL R7 missing boundaries: actual %0d pending expected 0", exp_q.size());
      end

      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule